// File: doc/BRIEF.md
# ECC Diagnostic Cache Array

This block is the storage core of a small set-associative cache. Each doubleword of a line is kept with its own single-error-correct, double-error-detect (SECDED) check bits, and so is each tag entry. A management port reads or writes one whole line, selected by separate set-index and way inputs. A two-bit diagnostic mode changes what a read or a write does.

Normal accesses generate check bits on write and correct or flag errors on read. Diagnostic writes can build the tag entry from fields of the write data. They can also store new data or new tag bits next to the check bits that the previous write stored, which plants a fault of known weight in the array. Diagnostic reads return the stored bits with correction bypassed. Every read also loads a read-tag register that exposes the tag entry and its stored check bits.

The block is meant for bring-up and for testing the ECC hardware and the recovery software. It has no replacement policy and no fill logic.

Top module: `ecc_diag_cache`

## Requirements
- R1: An asserted reset clears every tag entry to zero (address, valid, dirty and all check bits) and clears both saved check-bit registers. A normal read after reset reports valid 0, address 0, tag check bits 0 and no tag flags.
- R2: `rsp_valid` is high for exactly the one clock that follows a read request. A write produces no response.
- R3: After a mode 2'b00 write, a normal read returns the line unchanged with no flags. The tag entry reads back as `req_tag`, with valid 1 and dirty 0.
- R4: A data word whose stored check bits belong to a word that differs from it in one bit reads back as that other word, and `rsp_data_cor` is raised. A two-bit difference raises `rsp_data_unc`.
- R5: A mode 2'b01 read returns the stored data and the stored tag bits with no correction, and all four flags are low.
- R6: A mode 2'b01 write builds the tag entry from the doubleword at byte offset 0x18 (line bits [223:192]): address from its bits [23:0], valid from bit 24, dirty from bit 25. The entry gets freshly generated check bits, so a normal read shows it with no tag flags.
- R7: A mode 2'b10 write stores the new data with the data check bits that the previous write stored, not with freshly generated ones.
- R8: A mode 2'b11 write builds the tag as in R6 but stores the tag check bits of the previous write. `rtag_chk` then shows exactly those check bits.
- R9: A tag entry one bit away from the entry its check bits belong to raises `rsp_tag_cor`, and the read-tag register holds the corrected entry. A two-bit distance raises `rsp_tag_unc`, and the register holds the stored bits.
- R10: Reads in modes 2'b10 and 2'b11 behave exactly like mode 2'b00 reads.
- R11: The saved data and tag check-bit registers take the stored check bits on every write, whatever the mode, and hold between writes.
- R12: The read-tag outputs change only on a read. Writes leave them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mode | input | 2 | Diagnostic mode (00 normal, 01 raw/tag-from-data, 10 stale data check bits, 11 stale tag check bits) |
| req_index | input | 4 | Set index |
| req_way | input | 1 | Way select |
| req_tag | input | 24 | Tag address for mode 00/10 writes |
| req_wdata | input | 256 | Write line, doubleword n at bits [64n+63:64n] |
| rsp_valid | output | 1 | Read response strobe |
| rsp_data | output | 256 | Read line |
| rsp_data_cor | output | 1 | A data word was corrected |
| rsp_data_unc | output | 1 | A data word had an uncorrectable error |
| rsp_tag_cor | output | 1 | Tag entry was corrected |
| rsp_tag_unc | output | 1 | Tag entry had an uncorrectable error |
| rtag_addr | output | 24 | Read-tag register: address bits |
| rtag_valid | output | 1 | Read-tag register: valid bit |
| rtag_dirty | output | 1 | Read-tag register: dirty bit |
| rtag_chk | output | 6 | Read-tag register: stored tag check bits |

## Verification
The bench plants single-bit and double-bit faults in data words and in tag entries through stale check bits. A design that regenerated check bits on a diagnostic write would show no flags. A design that swapped the decode cases would return wrong data or the uncorrected tag. It puts an unrelated write between two plant steps, which catches saved check-bit registers that skip some modes or fail to follow every write. It reads with correction bypassed and in the reserved read modes, and it compares `rtag_chk` against the value seen earlier. These reads expose a bypass that still corrects, reserved modes that act raw, and tag check bits taken from the wrong source.

// File: rtl/ecc_diag_pkg.sv
package ecc_diag_pkg;

  typedef enum logic [1:0] {
    DG_NORMAL      = 2'b00,
    DG_RAW_TAGDATA = 2'b01,
    DG_OLD_DCHK    = 2'b10,
    DG_OLD_TCHK    = 2'b11
  } diag_mode_e;

  // Hamming bits needed to cover k payload bits (overall parity excluded).
  function automatic int hamming_bits(input int k);
    int res;
    res = 0;
    for (int r = 1; r < 16; r++) begin
      if (res == 0 && (1 << r) >= k + r + 1) res = r;
    end
    return res;
  endfunction

  // Codeword position of payload bit i (positions that are not powers of two).
  function automatic int data_pos(input int i);
    int cnt;
    int res;
    cnt = 0;
    res = 0;
    for (int q = 3; q < 256; q++) begin
      if ((q & (q - 1)) != 0) begin
        if (cnt == i) res = q;
        cnt++;
      end
    end
    return res;
  endfunction

  // Payload bits that feed Hamming check bit j.
  function automatic logic [127:0] col_mask(input int j, input int k);
    logic [127:0] m;
    m = '0;
    for (int i = 0; i < k; i++) begin
      if (((data_pos(i) >> j) & 1) == 1) m[i] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/ecc_secded_enc.sv
module ecc_secded_enc
  import ecc_diag_pkg::*;
#(
  parameter int K  = 64,
  parameter int CW = hamming_bits(K) + 1
) (
  input  logic [K-1:0]  d_in,
  output logic [CW-1:0] chk_out
);
  localparam int R = CW - 1;

  logic [R-1:0] ham;

  for (genvar j = 0; j < R; j++) begin : g_ham
    localparam logic [127:0] MASK = col_mask(j, K);
    assign ham[j] = ^(d_in & MASK[K-1:0]);
  end

  assign chk_out = {^{d_in, ham}, ham};
endmodule

// File: rtl/ecc_secded_dec.sv
module ecc_secded_dec
  import ecc_diag_pkg::*;
#(
  parameter int K  = 64,
  parameter int CW = hamming_bits(K) + 1
) (
  input  logic [K-1:0]  d_in,
  input  logic [CW-1:0] chk_in,
  output logic [K-1:0]  d_fix,
  output logic          cor,
  output logic          unc
);
  localparam int R = CW - 1;

  logic [CW-1:0] regen;
  logic [R-1:0]  syn;
  logic          par_err;
  logic [K-1:0]  flip;

  ecc_secded_enc #(.K(K), .CW(CW)) u_regen (
    .d_in    (d_in),
    .chk_out (regen)
  );

  assign syn     = chk_in[R-1:0] ^ regen[R-1:0];
  assign par_err = ^{d_in, chk_in};

  for (genvar i = 0; i < K; i++) begin : g_flip
    localparam int P = data_pos(i);
    assign flip[i] = par_err && (syn == R'(P));
  end

  assign d_fix = d_in ^ flip;
  assign cor   = par_err;
  assign unc   = !par_err && (syn != '0);
endmodule

// File: rtl/ecc_tag_store.sv
module ecc_tag_store #(
  parameter int DEPTH = 32,
  parameter int EW    = 32,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [EW-1:0] wentry,
  input  logic [AW-1:0] raddr,
  output logic [EW-1:0] rentry
);
  logic [DEPTH-1:0][EW-1:0] ent_q;
  logic [DEPTH-1:0][EW-1:0] ent_d;

  always_comb begin
    ent_d = ent_q;
    if (we) ent_d[waddr] = wentry;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ent_q <= '0;
    else        ent_q <= ent_d;
  end

  assign rentry = ent_q[raddr];
endmodule

// File: rtl/ecc_data_store.sv
module ecc_data_store #(
  parameter int DEPTH = 32,
  parameter int LW    = 288,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [LW-1:0] wline,
  input  logic [AW-1:0] raddr,
  output logic [LW-1:0] rline
);
  logic [LW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wline;
  end

  assign rline = mem[raddr];
endmodule

// File: rtl/ecc_diag_cache.sv
module ecc_diag_cache
  import ecc_diag_pkg::*;
#(
  parameter int SETS         = 16,
  parameter int WAYS         = 2,
  parameter int WORD_W       = 64,
  parameter int WORDS        = 4,
  parameter int TAG_ADDR_W   = 24,
  parameter int TAG_SRC_WORD = 3,
  localparam int IDX_W  = $clog2(SETS),
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int LINE_W = WORD_W * WORDS,
  localparam int TAG_W  = TAG_ADDR_W + 2,
  localparam int TCW    = hamming_bits(TAG_W) + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic                  req_write,
  input  logic [1:0]            req_mode,
  input  logic [IDX_W-1:0]      req_index,
  input  logic [WAY_W-1:0]      req_way,
  input  logic [TAG_ADDR_W-1:0] req_tag,
  input  logic [LINE_W-1:0]     req_wdata,
  output logic                  rsp_valid,
  output logic [LINE_W-1:0]     rsp_data,
  output logic                  rsp_data_cor,
  output logic                  rsp_data_unc,
  output logic                  rsp_tag_cor,
  output logic                  rsp_tag_unc,
  output logic [TAG_ADDR_W-1:0] rtag_addr,
  output logic                  rtag_valid,
  output logic                  rtag_dirty,
  output logic [TCW-1:0]        rtag_chk
);
  localparam int DCW   = hamming_bits(WORD_W) + 1;
  localparam int EW    = WORD_W + DCW;
  localparam int DEPTH = SETS * WAYS;
  localparam int AW    = $clog2(DEPTH);

  // ---------------- reset release synchronizer ----------------
  logic [1:0] rst_pipe;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ni = rst_pipe[1];

  // ---------------- request decode ----------------
  diag_mode_e mode;
  logic       is_wr;
  logic       is_rd;
  logic [AW-1:0] addr;

  assign mode  = diag_mode_e'(req_mode);
  assign is_wr = rst_ni && req_valid && req_write;
  assign is_rd = rst_ni && req_valid && !req_write;
  assign addr  = AW'(req_index * WAYS + req_way);

  // ---------------- saved check bits ----------------
  logic [WORDS-1:0][DCW-1:0] saved_dchk_q, saved_dchk_d;
  logic [TCW-1:0]            saved_tchk_q, saved_tchk_d;
  logic [WORDS-1:0][DCW-1:0] st_dchk;
  logic [TCW-1:0]            st_tchk;

  // ---------------- data path ----------------
  logic [WORDS*EW-1:0] wr_line;
  logic [WORDS*EW-1:0] rd_line;
  logic [LINE_W-1:0]   raw_data;
  logic [LINE_W-1:0]   fix_data;
  logic [WORDS-1:0]    cor_w;
  logic [WORDS-1:0]    unc_w;

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic [WORD_W-1:0] wd;
    logic [DCW-1:0]    fresh;
    logic [WORD_W-1:0] rd_word;
    logic [DCW-1:0]    rd_chk;
    logic [WORD_W-1:0] fixed;

    assign wd = req_wdata[w*WORD_W +: WORD_W];

    ecc_secded_enc #(.K(WORD_W), .CW(DCW)) u_denc (
      .d_in    (wd),
      .chk_out (fresh)
    );

    assign st_dchk[w] = (mode == DG_OLD_DCHK) ? saved_dchk_q[w] : fresh;
    assign wr_line[w*EW +: EW] = {st_dchk[w], wd};

    assign rd_word = rd_line[w*EW +: WORD_W];
    assign rd_chk  = rd_line[w*EW + WORD_W +: DCW];

    ecc_secded_dec #(.K(WORD_W), .CW(DCW)) u_ddec (
      .d_in   (rd_word),
      .chk_in (rd_chk),
      .d_fix  (fixed),
      .cor    (cor_w[w]),
      .unc    (unc_w[w])
    );

    assign raw_data[w*WORD_W +: WORD_W] = rd_word;
    assign fix_data[w*WORD_W +: WORD_W] = fixed;
  end

  ecc_data_store #(.DEPTH(DEPTH), .LW(WORDS*EW), .AW(AW)) u_data (
    .clk   (clk),
    .we    (is_wr),
    .waddr (addr),
    .wline (wr_line),
    .raddr (addr),
    .rline (rd_line)
  );

  // ---------------- tag path ----------------
  logic [TAG_W-1:0]     tag_from_data;
  logic [TAG_W-1:0]     tag_plain;
  logic [TAG_W-1:0]     wtag;
  logic                 build_from_data;
  logic [TCW-1:0]       fresh_tchk;
  logic [TCW+TAG_W-1:0] rd_tent;
  logic [TAG_W-1:0]     raw_tag;
  logic [TCW-1:0]       raw_tchk;
  logic [TAG_W-1:0]     fix_tag;
  logic                 tcor;
  logic                 tunc;

  assign tag_from_data   = req_wdata[TAG_SRC_WORD*WORD_W +: TAG_W];
  assign tag_plain       = {1'b0, 1'b1, req_tag};
  assign build_from_data = (mode == DG_RAW_TAGDATA) || (mode == DG_OLD_TCHK);
  assign wtag            = build_from_data ? tag_from_data : tag_plain;

  ecc_secded_enc #(.K(TAG_W), .CW(TCW)) u_tenc (
    .d_in    (wtag),
    .chk_out (fresh_tchk)
  );

  assign st_tchk = (mode == DG_OLD_TCHK) ? saved_tchk_q : fresh_tchk;

  ecc_tag_store #(.DEPTH(DEPTH), .EW(TCW+TAG_W), .AW(AW)) u_tag (
    .clk    (clk),
    .rst_n  (rst_ni),
    .we     (is_wr),
    .waddr  (addr),
    .wentry ({st_tchk, wtag}),
    .raddr  (addr),
    .rentry (rd_tent)
  );

  assign raw_tag  = rd_tent[TAG_W-1:0];
  assign raw_tchk = rd_tent[TAG_W +: TCW];

  ecc_secded_dec #(.K(TAG_W), .CW(TCW)) u_tdec (
    .d_in   (raw_tag),
    .chk_in (raw_tchk),
    .d_fix  (fix_tag),
    .cor    (tcor),
    .unc    (tunc)
  );

  // ---------------- saved check-bit registers ----------------
  always_comb begin
    saved_dchk_d = saved_dchk_q;
    saved_tchk_d = saved_tchk_q;
    if (is_wr) begin
      saved_dchk_d = st_dchk;
      saved_tchk_d = st_tchk;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      saved_dchk_q <= '0;
      saved_tchk_q <= '0;
    end else begin
      saved_dchk_q <= saved_dchk_d;
      saved_tchk_q <= saved_tchk_d;
    end
  end

  // ---------------- response registers ----------------
  logic              raw_rd;
  logic              rsp_valid_q, rsp_valid_d;
  logic [LINE_W-1:0] rsp_data_q, rsp_data_d;
  logic [3:0]        flags_q, flags_d;
  logic [TAG_W-1:0]  rtag_q, rtag_d;
  logic [TCW-1:0]    rchk_q, rchk_d;

  assign raw_rd = (mode == DG_RAW_TAGDATA);

  always_comb begin
    rsp_valid_d = is_rd;
    rsp_data_d  = rsp_data_q;
    flags_d     = flags_q;
    rtag_d      = rtag_q;
    rchk_d      = rchk_q;
    if (is_rd) begin
      rsp_data_d = raw_rd ? raw_data : fix_data;
      flags_d    = raw_rd ? 4'b0000 : {tunc, tcor, |unc_w, |cor_w};
      rtag_d     = raw_rd ? raw_tag : fix_tag;
      rchk_d     = raw_tchk;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      flags_q     <= '0;
      rtag_q      <= '0;
      rchk_q      <= '0;
    end else begin
      rsp_valid_q <= rsp_valid_d;
      if (is_rd) begin
        flags_q <= flags_d;
        rtag_q  <= rtag_d;
        rchk_q  <= rchk_d;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (is_rd) rsp_data_q <= rsp_data_d;
  end

  assign rsp_valid    = rsp_valid_q;
  assign rsp_data     = rsp_data_q;
  assign rsp_data_cor = flags_q[0];
  assign rsp_data_unc = flags_q[1];
  assign rsp_tag_cor  = flags_q[2];
  assign rsp_tag_unc  = flags_q[3];
  assign rtag_addr    = rtag_q[TAG_ADDR_W-1:0];
  assign rtag_valid   = rtag_q[TAG_ADDR_W];
  assign rtag_dirty   = rtag_q[TAG_ADDR_W+1];
  assign rtag_chk     = rchk_q;

  // ---------------- assertions ----------------
  assert_rsp_after_read_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    is_rd |=> rsp_valid);

  assert_no_rsp_otherwise_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    !is_rd |=> !rsp_valid);

  assert_raw_read_no_flags_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    (is_rd && req_mode == 2'b01) |=>
      !(rsp_data_cor || rsp_data_unc || rsp_tag_cor || rsp_tag_unc));

  assert_tag_flags_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    rsp_valid |-> !(rsp_tag_cor && rsp_tag_unc));

  assert_saved_hold_idle_R11: assert property (@(posedge clk) disable iff (!rst_ni)
    !is_wr |=> ($stable(saved_dchk_q) && $stable(saved_tchk_q)));

  assert_stale_dchk_kept_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    (is_wr && req_mode == 2'b10) |=> $stable(saved_dchk_q));

  assert_stale_tchk_kept_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    (is_wr && req_mode == 2'b11) |=> $stable(saved_tchk_q));

  assert_rtag_hold_R12: assert property (@(posedge clk) disable iff (!rst_ni)
    !is_rd |=> ($stable(rtag_addr) && $stable(rtag_valid) &&
                $stable(rtag_dirty) && $stable(rtag_chk)));
endmodule

// File: tb/ecc_diag_cache_bench.sv
`timescale 1ns/1ps
module ecc_diag_cache_bench;
  logic         clk;
  logic         rst_n;
  logic         req_valid;
  logic         req_write;
  logic [1:0]   req_mode;
  logic [3:0]   req_index;
  logic [0:0]   req_way;
  logic [23:0]  req_tag;
  logic [255:0] req_wdata;
  logic         rsp_valid;
  logic [255:0] rsp_data;
  logic         rsp_data_cor, rsp_data_unc, rsp_tag_cor, rsp_tag_unc;
  logic [23:0]  rtag_addr;
  logic         rtag_valid, rtag_dirty;
  logic [5:0]   rtag_chk;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  ecc_diag_cache u_ecc_diag_cache (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_mode(req_mode), .req_index(req_index), .req_way(req_way),
    .req_tag(req_tag), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .rsp_data_cor(rsp_data_cor), .rsp_data_unc(rsp_data_unc),
    .rsp_tag_cor(rsp_tag_cor), .rsp_tag_unc(rsp_tag_unc), .rtag_addr(rtag_addr),
    .rtag_valid(rtag_valid), .rtag_dirty(rtag_dirty), .rtag_chk(rtag_chk)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Reference model: stored bits and the bits the stored check bits belong to.
  logic [63:0] m_dat  [32][4];
  logic [63:0] m_dref [32][4];
  bit          m_known[32];
  logic [25:0] m_tag  [32];
  logic [25:0] m_tref [32];
  logic [63:0] prev_dref[4];
  logic [25:0] prev_tref;

  task automatic ck(input string rq, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [255:0] mk(input logic [63:0] s);
    return {s + 64'h3333_1111_7777_5555, ~s, s ^ 64'hA5A5_A5A5_5A5A_5A5A, s};
  endfunction

  function automatic logic [255:0] tline(input logic [63:0] s, input logic [25:0] t);
    logic [255:0] l;
    l = mk(s);
    l[192 +: 26] = t;
    return l;
  endfunction

  task automatic wr(input logic [1:0] md, input int idx, input int way,
                    input logic [23:0] tg, input logic [255:0] line);
    int loc;
    logic [25:0] t;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_mode = md;
    req_index = 4'(idx); req_way = 1'(way); req_tag = tg; req_wdata = line;
    @(negedge clk);
    req_valid = 1'b0;
    ck("R2 no response after write", 256'(rsp_valid), 256'(0));
    loc = idx * 2 + way;
    for (int w = 0; w < 4; w++) begin
      m_dat[loc][w]  = line[w*64 +: 64];
      m_dref[loc][w] = (md == 2'b10) ? prev_dref[w] : line[w*64 +: 64];
      prev_dref[w]   = m_dref[loc][w];
    end
    m_known[loc] = 1'b1;
    t = (md == 2'b01 || md == 2'b11) ? line[192 +: 26] : {2'b01, tg};
    m_tag[loc]  = t;
    m_tref[loc] = (md == 2'b11) ? prev_tref : t;
    prev_tref   = m_tref[loc];
  endtask

  task automatic rd(input logic [1:0] md, input int idx, input int way, input string rq);
    int loc;
    int dt;
    bit ec, eu;
    logic [25:0] et;
    loc = idx * 2 + way;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_mode = md;
    req_index = 4'(idx); req_way = 1'(way);
    @(negedge clk);
    req_valid = 1'b0;
    ck({rq, " R2 rsp_valid"}, 256'(rsp_valid), 256'(1));
    ec = 0; eu = 0;
    if (m_known[loc]) begin
      for (int w = 0; w < 4; w++) begin
        dt = $countones(m_dat[loc][w] ^ m_dref[loc][w]);
        if (md == 2'b01 || dt == 0)
          ck({rq, " data word"}, 256'(rsp_data[w*64 +: 64]), 256'(m_dat[loc][w]));
        else if (dt == 1) begin
          ec = 1;
          ck({rq, " corrected data word"}, 256'(rsp_data[w*64 +: 64]), 256'(m_dref[loc][w]));
        end else eu = 1;
      end
      if (md == 2'b01) begin ec = 0; eu = 0; end
      ck({rq, " data flags"}, 256'({rsp_data_unc, rsp_data_cor}), 256'({eu, ec}));
    end
    dt = $countones(m_tag[loc] ^ m_tref[loc]);
    et = (md != 2'b01 && dt == 1) ? m_tref[loc] : m_tag[loc];
    ck({rq, " read-tag entry"}, 256'({rtag_dirty, rtag_valid, rtag_addr}), 256'(et));
    ck({rq, " tag flags"}, 256'({rsp_tag_unc, rsp_tag_cor}),
       (md == 2'b01) ? 256'(0) : 256'({dt >= 2, dt == 1}));
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [5:0]   c_saved;
    logic [255:0] l;
    logic [25:0]  t;
    for (int i = 0; i < 32; i++) begin
      m_known[i] = 0; m_tag[i] = '0; m_tref[i] = '0;
    end
    for (int w = 0; w < 4; w++) prev_dref[w] = '0;
    prev_tref = '0;
    req_valid = 0; req_write = 0; req_mode = 0; req_index = 0; req_way = 0;
    req_tag = 0; req_wdata = '0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    ck("R1 rsp_valid after reset", 256'(rsp_valid), 256'(0));
    rd(2'b00, 0, 0, "R1 read after reset");
    ck("R1 tag check bits after reset", 256'(rtag_chk), 256'(0));
    rd(2'b00, 15, 1, "R1 read last entry after reset");

    // R3: plain write/read
    wr(2'b00, 1, 0, 24'hABCDEF, mk(64'h0123_4567_89AB_CDEF));
    rd(2'b00, 1, 0, "R3 normal");
    // R10: reserved read modes
    rd(2'b10, 1, 0, "R10 mode10 read");
    rd(2'b11, 1, 0, "R10 mode11 read");
    // R5: raw read
    rd(2'b01, 1, 0, "R5 raw read");

    // R4/R7: single-bit data plant through stale check bits
    l = mk(64'hDEAD_BEEF_0000_1111);
    wr(2'b00, 2, 1, 24'h000222, l);
    l[5] = ~l[5];
    l[128+63] = ~l[128+63];
    wr(2'b10, 2, 1, 24'h000222, l);
    rd(2'b00, 2, 1, "R4 R7 single data plant");
    rd(2'b01, 2, 1, "R5 raw read of planted data");

    // R4/R7: double-bit data plant
    l = mk(64'h5555_0000_FFFF_1234);
    wr(2'b00, 3, 0, 24'h000333, l);
    l[64] = ~l[64];
    l[65] = ~l[65];
    wr(2'b10, 3, 0, 24'h000333, l);
    rd(2'b00, 3, 0, "R4 R7 double data plant");

    // R11: saved bits follow every write
    wr(2'b00, 4, 0, 24'h000444, mk(64'h1111_2222_3333_4444));
    l = mk(64'h9876_5432_1000_0FED);
    wr(2'b00, 5, 0, 24'h000555, l);
    l[200] = ~l[200];
    wr(2'b10, 6, 1, 24'h000666, l);
    rd(2'b00, 6, 1, "R11 stale bits from latest write");

    // R6: tag built from data, fresh check bits
    wr(2'b01, 7, 0, 24'h0, tline(64'h4242_4242_0000_0001, {2'b11, 24'h123456}));
    rd(2'b00, 7, 0, "R6 tag from data");

    // R8/R9: single-bit tag plant
    t = {2'b01, 24'h0F0F0F};
    wr(2'b01, 8, 1, 24'h0, tline(64'h7777_0000_1234_0000, t));
    rd(2'b00, 8, 1, "R8 reference tag");
    c_saved = rtag_chk;
    t[3] = ~t[3];
    wr(2'b11, 8, 1, 24'h0, tline(64'h7777_0000_1234_0000, t));
    rd(2'b00, 8, 1, "R9 single tag plant");
    ck("R8 stale tag check bits visible", 256'(rtag_chk), 256'(c_saved));

    // R12: writes leave read-tag register alone
    wr(2'b00, 10, 0, 24'hFFFFFF, mk(64'h0));
    ck("R12 read-tag after write", 256'({rtag_dirty, rtag_valid, rtag_addr, rtag_chk}),
       256'({2'b01, 24'h0F0F0F, c_saved}));

    // R9: double-bit tag plant
    t = {2'b11, 24'hC0FFEE};
    wr(2'b01, 9, 0, 24'h0, tline(64'h1, t));
    t[0] = ~t[0];
    t[25] = ~t[25];
    wr(2'b11, 9, 0, 24'h0, tline(64'h1, t));
    rd(2'b00, 9, 0, "R9 double tag plant");
    rd(2'b01, 9, 0, "R5 raw read of planted tag");

    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule